// File: doc/BRIEF.md
# Programmable Ratio Clock Divider

This block divides a single reference clock by a ratio held in a bit field of a 32-bit control register. Software, or any simple master, writes the register through a one-cycle write strobe and can read it back at any time. A parameter picks how the field value maps to a divisor. The choices are value plus one, value taken as is, two to the power of the value, value taken as is with zero also meaning one, or a small lookup table of (code, divisor) pairs. The field is located by an in-place bit mask and a right shift. When no shift is given, the shift comes from the lowest set bit of the mask.

Each register write is decoded one cycle later into a pending divisor. A field value that is rejected leaves the pending divisor unchanged. A value is rejected when it has no encoding, has no table entry, or falls outside the configured minimum and maximum divisor. The running divider adopts the pending divisor only when its current output period ends, so a change never shortens a phase. An optional masked-write mode keeps only the low 16 bits of the register. In that mode the upper 16 bits of each write act as per-bit write enables. There is no gating and only one input clock.

Top module: `regdiv_clock`

## Requirements
- R1: During and straight after reset the register reads 0 and the output follows the input clock (divide by 1).
- R2: In the plus-one encoding, field value v gives divisor v+1 (0 gives 1, 3 gives 4).
- R3: In the as-is encoding, field value v gives divisor v, and v = 0 is rejected.
- R4: In the power-of-two encoding, field value v gives divisor 2^v (0 gives 1, 2 gives 4).
- R5: In the zero-allowed encoding, field value v gives divisor v, except that v = 0 gives divisor 1.
- R6: In the table encoding, the field is matched against the table codes (defaults: code 0 gives 4, code 1 gives 8, code 2 gives 3). A code with no entry is rejected.
- R7: The field is (register AND mask) shifted right. With the shift left at its default, the shift equals the index of the lowest set mask bit. Register bits outside the mask are stored but do not affect the ratio.
- R8: In masked-write mode, write bit 16+i enables update of register bit i from write bit i. Register bits 31:16 always read 0.
- R9: A divisor below the minimum or above the maximum is rejected. A rejected value leaves the previous divisor in effect.
- R10: A new divisor is taken up only at the end of the current output period. The pending value is updated one cycle after the write.
- R11: For a divisor N ≥ 2 the output is high for floor(N/2) input cycles and then low for the rest. The output is 50% for even N, and the high phase is one cycle shorter for odd N. For N = 1 the output is the input clock.
- R12: A read returns the register contents one cycle after the write, without delay on the read side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register contents |
| clk_out | output | 1 | Divided clock |

## Verification
Two functions can meet in a single cycle. One is the update of the pending divisor from a freshly written field. The other is the end-of-period swap that loads that pending divisor into the running divider. The bench writes at many offsets inside running periods, including rejected values and back-to-back changes. It also checks that a write landing in the last cycle of a period is taken up by either the current swap or the next, as the one-cycle decode latency dictates. A behavioural model predicts the output level in both halves of every input cycle and the read value, and every difference is reported.

// File: rtl/regdiv_pkg.sv
package regdiv_pkg;

  typedef enum logic [2:0] {
    DEC_PLUS1   = 3'd0,
    DEC_ASIS    = 3'd1,
    DEC_POW2    = 3'd2,
    DEC_ZERO_OK = 3'd3,
    DEC_TABLE   = 3'd4
  } dec_mode_e;

  // index of the lowest set bit, 0 for an empty mask
  function automatic int low_bit(input logic [31:0] m);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/regdiv_ctrl_reg.sv
module regdiv_ctrl_reg #(
  parameter int REG_W  = 32,
  parameter bit HIWORD = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);
  localparam int HALF = REG_W / 2;

  generate
    if (HIWORD) begin : g_masked
      logic [HALF-1:0] lo_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          lo_q <= '0;
        end else if (wr_en) begin
          lo_q <= (lo_q & ~wr_data[REG_W-1:HALF]) |
                  (wr_data[HALF-1:0] & wr_data[REG_W-1:HALF]);
        end
      end
      assign q = {{(REG_W-HALF){1'b0}}, lo_q};
    end else begin : g_plain
      logic [REG_W-1:0] full_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          full_q <= '0;
        end else if (wr_en) begin
          full_q <= wr_data;
        end
      end
      assign q = full_q;
    end
  endgenerate
endmodule

// File: rtl/regdiv_decode.sv
module regdiv_decode
  import regdiv_pkg::*;
#(
  parameter dec_mode_e                 MODE      = DEC_PLUS1,
  parameter logic [31:0]               MASK      = 32'h0000_00F0,
  parameter int                        SHIFT     = -1,
  parameter int                        MIN_DIV   = 1,
  parameter int                        MAX_DIV   = 16,
  parameter int                        DIV_W     = 5,
  parameter int                        TBL_N     = 3,
  parameter int                        TBL_EW    = 8,
  parameter logic [TBL_N*TBL_EW-1:0]   TBL_DIVS  = {8'd3, 8'd8, 8'd4},
  parameter logic [TBL_N*TBL_EW-1:0]   TBL_CODES = {8'd2, 8'd1, 8'd0}
) (
  input  logic [31:0]      ctrl,
  output logic             ok,
  output logic [DIV_W-1:0] div
);
  localparam int SH = (SHIFT >= 0) ? SHIFT : low_bit(MASK);

  logic [31:0] fld;
  logic [31:0] raw;
  logic        enc_ok;

  assign fld = (ctrl & MASK) >> SH;

  generate
    if (MODE == DEC_TABLE) begin : g_table
      always_comb begin
        enc_ok = 1'b0;
        raw    = '0;
        for (int i = 0; i < TBL_N; i++) begin
          if (fld == 32'(TBL_CODES[i*TBL_EW +: TBL_EW])) begin
            enc_ok = 1'b1;
            raw    = 32'(TBL_DIVS[i*TBL_EW +: TBL_EW]);
          end
        end
      end
    end else begin : g_arith
      always_comb begin
        enc_ok = 1'b1;
        raw    = '0;
        case (MODE)
          DEC_PLUS1:   raw = fld + 32'd1;
          DEC_ASIS: begin
            raw    = fld;
            enc_ok = (fld != '0);
          end
          DEC_POW2: begin
            enc_ok = (fld < 32'd31);
            raw    = enc_ok ? (32'd1 << fld[4:0]) : '0;
          end
          DEC_ZERO_OK: raw = (fld == '0) ? 32'd1 : fld;
          default:     enc_ok = 1'b0;
        endcase
      end
    end
  endgenerate

  assign ok  = enc_ok && (raw >= 32'(MIN_DIV)) && (raw <= 32'(MAX_DIV));
  assign div = raw[DIV_W-1:0];
endmodule

// File: rtl/regdiv_gen.sv
module regdiv_gen #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] pend_div,
  output logic [DIV_W-1:0] cur_div,
  output logic [DIV_W-1:0] cnt,
  output logic             hi_q,
  output logic             clk_out
);
  logic end_prd;

  assign end_prd = (cur_div == DIV_W'(1)) || (cnt == cur_div - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_div <= DIV_W'(1);
      cnt     <= '0;
      hi_q    <= 1'b0;
    end else if (end_prd) begin
      cur_div <= pend_div;
      cnt     <= '0;
      hi_q    <= (pend_div >> 1) != '0;
    end else begin
      cnt     <= cnt + 1'b1;
      hi_q    <= (cnt + 1'b1) < (cur_div >> 1);
    end
  end

  // divide-by-1 routes the reference through; select only moves at a period end
  assign clk_out = (cur_div == DIV_W'(1)) ? clk : hi_q;
endmodule

// File: rtl/regdiv_clock.sv
module regdiv_clock
  import regdiv_pkg::*;
#(
  parameter dec_mode_e                 MODE      = DEC_PLUS1,
  parameter logic [31:0]               MASK      = 32'h0000_00F0,
  parameter int                        SHIFT     = -1,
  parameter int                        MIN_DIV   = 1,
  parameter int                        MAX_DIV   = 16,
  parameter bit                        HIWORD    = 1'b0,
  parameter int                        TBL_N     = 3,
  parameter int                        TBL_EW    = 8,
  parameter logic [TBL_N*TBL_EW-1:0]   TBL_DIVS  = {8'd3, 8'd8, 8'd4},
  parameter logic [TBL_N*TBL_EW-1:0]   TBL_CODES = {8'd2, 8'd1, 8'd0}
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        clk_out
);
  localparam int DIV_W = $clog2(MAX_DIV + 1);

  logic [31:0]      ctrl_q;
  logic             dec_ok;
  logic [DIV_W-1:0] dec_div;
  logic [DIV_W-1:0] pend_div;
  logic [DIV_W-1:0] cur_div;
  logic [DIV_W-1:0] cnt;
  logic             hi_q;

  regdiv_ctrl_reg #(.REG_W(32), .HIWORD(HIWORD)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .q(ctrl_q)
  );

  regdiv_decode #(
    .MODE(MODE), .MASK(MASK), .SHIFT(SHIFT), .MIN_DIV(MIN_DIV),
    .MAX_DIV(MAX_DIV), .DIV_W(DIV_W), .TBL_N(TBL_N), .TBL_EW(TBL_EW),
    .TBL_DIVS(TBL_DIVS), .TBL_CODES(TBL_CODES)
  ) u_dec (
    .ctrl(ctrl_q), .ok(dec_ok), .div(dec_div)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_div <= DIV_W'(1);
    end else if (dec_ok) begin
      pend_div <= dec_div;
    end
  end

  regdiv_gen #(.DIV_W(DIV_W)) u_gen (
    .clk(clk), .rst(rst), .pend_div(pend_div), .cur_div(cur_div),
    .cnt(cnt), .hi_q(hi_q), .clk_out(clk_out)
  );

  assign rd_data = ctrl_q;
endmodule

// File: rtl/regdiv_clock_chk.sv
module regdiv_clock_chk #(
  parameter int DIV_W   = 5,
  parameter int MIN_DIV = 1,
  parameter int MAX_DIV = 16,
  parameter bit HIWORD  = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      rd_data,
  input logic             dec_ok,
  input logic [DIV_W-1:0] pend_div,
  input logic [DIV_W-1:0] cur_div,
  input logic [DIV_W-1:0] cnt,
  input logic             hi_q
);
  // R10: running divisor moves only after the last cycle of a period
  a_r10_swap_at_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_div) |-> ($past(cur_div) == DIV_W'(1) ||
                           $past(cnt) == $past(cur_div) - 1'b1));

  // R9: pending divisor changes only from an accepted field
  a_r9_pend_from_valid: assert property (@(posedge clk) disable iff (rst)
    !$stable(pend_div) |-> $past(dec_ok));

  // R9: running divisor is 1 (reset) or inside the limits
  a_r9_range: assert property (@(posedge clk) disable iff (rst)
    cur_div == DIV_W'(1) ||
    (cur_div >= DIV_W'(MIN_DIV) && cur_div <= DIV_W'(MAX_DIV)));

  // R11: phase counter stays inside the period
  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < cur_div || cur_div == DIV_W'(1));

  // R11: every period of N >= 2 opens with a high phase
  a_r11_open_high: assert property (@(posedge clk) disable iff (rst)
    (cur_div > DIV_W'(1) && cnt == '0) |-> hi_q);

  // R8: upper half reads zero in masked-write mode
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    HIWORD |-> rd_data[31:16] == 16'h0);
endmodule

bind regdiv_clock regdiv_clock_chk #(
  .DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .HIWORD(HIWORD)
) u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .dec_ok(dec_ok),
  .pend_div(pend_div), .cur_div(cur_div), .cnt(cnt), .hi_q(hi_q)
);

// File: tb/regdiv_clock_bench.sv
module regdiv_clock_bench;
  import regdiv_pkg::*;

  localparam int NU = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en   [NU];
  logic [31:0] wr_data [NU];
  logic [31:0] rd_data [NU];
  logic        clk_out [NU];

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  bit    chk_on = 1'b0;
  string req = "R1";

  always #5 clk = ~clk;

  // unit 0: plus-one, field at bits 7:4, limits 2..12
  regdiv_clock #(.MODE(DEC_PLUS1), .MASK(32'h0000_00F0), .MIN_DIV(2), .MAX_DIV(12))
    u_regdiv_clock (.clk(clk), .rst(rst), .wr_en(wr_en[0]), .wr_data(wr_data[0]),
                    .rd_data(rd_data[0]), .clk_out(clk_out[0]));
  regdiv_clock #(.MODE(DEC_ASIS), .MASK(32'h0000_000F), .SHIFT(0), .MAX_DIV(15))
    u_regdiv_clock_asis (.clk(clk), .rst(rst), .wr_en(wr_en[1]), .wr_data(wr_data[1]),
                         .rd_data(rd_data[1]), .clk_out(clk_out[1]));
  regdiv_clock #(.MODE(DEC_POW2), .MASK(32'h0000_0007), .MAX_DIV(16))
    u_regdiv_clock_pow2 (.clk(clk), .rst(rst), .wr_en(wr_en[2]), .wr_data(wr_data[2]),
                         .rd_data(rd_data[2]), .clk_out(clk_out[2]));
  regdiv_clock #(.MODE(DEC_ZERO_OK), .MASK(32'h0000_000F), .MAX_DIV(15))
    u_regdiv_clock_zero (.clk(clk), .rst(rst), .wr_en(wr_en[3]), .wr_data(wr_data[3]),
                         .rd_data(rd_data[3]), .clk_out(clk_out[3]));
  regdiv_clock #(.MODE(DEC_TABLE), .MASK(32'h0000_0003), .MAX_DIV(8), .HIWORD(1'b1))
    u_regdiv_clock_tbl (.clk(clk), .rst(rst), .wr_en(wr_en[4]), .wr_data(wr_data[4]),
                        .rd_data(rd_data[4]), .clk_out(clk_out[4]));

  // ---------------- reference model ----------------
  logic [31:0] m_ctrl [NU];
  int          m_pend [NU];
  int          m_cur  [NU];
  int          m_pos  [NU];

  // divisor for a register value, 0 when rejected
  function automatic int ref_div(int k, logic [31:0] r);
    int f, d;
    d = 0;
    case (k)
      0: begin f = int'(r[7:4]); d = f + 1; if (d < 2 || d > 12) d = 0; end
      1: begin f = int'(r[3:0]); d = f; if (d > 15) d = 0; end
      2: begin f = int'(r[2:0]); d = 1 << f; if (d > 16) d = 0; end
      3: begin f = int'(r[3:0]); d = (f == 0) ? 1 : f; end
      default: begin
        f = int'(r[1:0]);
        if (f == 0) d = 4; else if (f == 1) d = 8; else if (f == 2) d = 3; else d = 0;
      end
    endcase
    return d;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < NU; k++) begin
      if (rst) begin
        m_ctrl[k] = '0; m_pend[k] = 1; m_cur[k] = 1; m_pos[k] = 0;
      end else begin
        int d;
        logic [31:0] nc;
        d  = ref_div(k, m_ctrl[k]);
        nc = m_ctrl[k];
        if (wr_en[k]) begin
          if (k == 4)
            nc = {16'h0, (m_ctrl[k][15:0] & ~wr_data[k][31:16]) |
                         (wr_data[k][15:0] & wr_data[k][31:16])};
          else
            nc = wr_data[k];
        end
        if (m_pos[k] >= m_cur[k] - 1) begin
          m_cur[k] = m_pend[k];
          m_pos[k] = 0;
        end else begin
          m_pos[k] = m_pos[k] + 1;
        end
        if (d != 0) m_pend[k] = d;
        m_ctrl[k] = nc;
      end
    end
  end

  function automatic logic exp_out(int k, bit high_half);
    if (m_cur[k] == 1) return high_half;
    return (m_pos[k] < m_cur[k] / 2);
  endfunction

  task automatic check(string tag, string what, int k, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s unit %0d at %0t: actual %h expected %h", tag, what, k, $time, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (chk_on) begin
        for (int k = 0; k < NU; k++) begin
          check(req, "clk_out high half", k, 32'(clk_out[k]), 32'(exp_out(k, 1'b1)));
          check((k == 4) ? "R8" : "R12", "rd_data", k, rd_data[k], m_ctrl[k]);
        end
      end
      #5;
      if (chk_on) begin
        for (int k = 0; k < NU; k++)
          check(req, "clk_out low half", k, 32'(clk_out[k]), 32'(exp_out(k, 1'b0)));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int k, logic [31:0] d);
    @(negedge clk);
    wr_en[k]   = 1'b1;
    wr_data[k] = d;
    @(negedge clk);
    wr_en[k]   = 1'b0;
    wr_data[k] = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < NU; k++) begin
      wr_en[k] = 1'b0;
      wr_data[k] = '0;
    end
    @(posedge clk);
    chk_on = 1'b1;
    req = "R1";
    idle(4);
    rst = 1'b0;
    idle(10);

    // unit 0, plus-one encoding
    req = "R2";   wr(0, 32'h0000_0030); idle(30);
    req = "R11";  wr(0, 32'h0000_0040); idle(30);  // 5, odd
                  wr(0, 32'h0000_0050); idle(30);  // 6, even
    req = "R9";   wr(0, 32'h0000_0000); idle(20);  // 1 < min
                  wr(0, 32'h0000_00F0); idle(20);  // 16 > max
                  wr(0, 32'h0000_00B0); idle(40);  // 12 at max
    req = "R7";   wr(0, 32'hA5A5_FF25); idle(30);  // field 2 -> 3
    req = "R10";
    for (int off = 0; off < 8; off++) begin
      wr(0, 32'h0000_0070); idle(off);
      wr(0, 32'h0000_0020); idle(3 + off);
    end
    idle(20);

    // unit 1, as-is encoding
    req = "R3";
    wr(1, 32'd3); idle(20);
    wr(1, 32'd0); idle(20);  // rejected, stays 3
    wr(1, 32'd1); idle(10);
    wr(1, 32'd6); idle(30);

    // unit 2, power of two
    req = "R4";
    for (int v = 0; v < 6; v++) begin
      wr(2, 32'(v)); idle(40);  // v = 5 gives 32, rejected
    end

    // unit 3, zero allowed
    req = "R5";
    wr(3, 32'd2); idle(20);
    wr(3, 32'd0); idle(20);
    wr(3, 32'd7); idle(30);

    // unit 4, table with masked writes
    req = "R6";
    wr(4, 32'hFFFF_0001); idle(30);  // code 1 -> 8
    wr(4, 32'h0002_0002); idle(30);  // code 3 unmatched, stays 8
    req = "R8";
    wr(4, 32'h0001_0000); idle(30);  // clear bit 0 -> code 2 -> 3
    wr(4, 32'h0000_0003); idle(20);  // no enables, no change
    wr(4, 32'h0003_0000); idle(30);  // code 0 -> 4

    // all units together
    req = "R10";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      for (int k = 0; k < NU; k++) begin
        wr_en[k] = 1'b1;
        wr_data[k] = (k == 4) ? 32'h0003_0000 | 32'(i % 3) : 32'(i * 17 + k);
      end
      @(negedge clk);
      for (int k = 0; k < NU; k++) wr_en[k] = 1'b0;
      idle(5 + i);
    end
    idle(40);

    req = "R1";
    rst = 1'b1; idle(3);
    rst = 1'b0; idle(8);
    finish_run();
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      finish_run();
    end
  end
endmodule